// File: doc/BRIEF.md
# SPI Shift Engine with Single-Wire Data Mode

This block is a byte-wide SPI shift engine that can act as bus master or as a slave. A pin-routing layer sits in front of it and maps the engine onto four SPI pins. Each pin is modelled as an input, an output value and an output enable.

The block has two data modes. In the normal two-wire mode, MOSI and MISO carry the two directions separately. In the single-wire mode, one pin carries both directions. A master uses MOSI as that shared line and a slave uses MISO. The data pin the role does not need is handed back as a plain general-purpose pin. That pin is driven from a software data bit when its direction bit is set. The direction bit of the shared pin decides whether outgoing bits reach the line or are dropped. In either case the shift register samples whatever level the line carries.

In master mode, an automatic select option can drive SS low for the whole transfer. While that option is active, the mode-fault check is switched off. When the option is not active, a low level on the SS input of a master counts as a mode fault. A mode fault demotes the engine to slave and aborts any transfer in progress.

Top module: `spi1w_core`

## Requirements
- R1: When `spe`=1, the master SCK stays high for `(sppr+1)<<spr` clock cycles and low for the same count. Its period is therefore `(sppr+1)*2^(spr+1)` cycles.
- R2: A master transfer starts on `tx_start` while idle. It shifts 8 bits MSB first with SCK idling low and data sampled on the rising edge. When the last falling edge ends the transfer, `busy` drops, `done` pulses for exactly one cycle and `rx_data` holds the received byte.
- R3: When master, `ssoe`=1 and `cur_ddr[3]`=1, the SS pin is an output that is low in every cycle `busy` is high and high when idle.
- R4: In slave mode, SS and SCK are never driven (`ss_oe`=`sck_oe`=0), and with `spe`=0 no pin is driven.
- R5: A master with `spe`=1, SS input low and the automatic select option inactive raises a mode fault. On the next edge this sets sticky `fault`, clears `cur_mstr`, aborts the transfer with no `done` and ignores a `tx_start` given in the same cycle. `fault_clr` clears `fault`.
- R6: While the automatic select option is active, a low SS input never raises `fault`.
- R7: A mode fault clears direction bits 0 (MOSI) and 2 (SCK). It clears bit 1 (MISO) only when `bidi`=0.
- R8: In single-wire master mode, MOSI is the shared line. It is driven with shift data only when `cur_ddr[0]`=1, and its pin level is the serial input. MISO is general purpose: `miso_oe`=`cur_ddr[1]` and `miso_o`=`gpo_dat[1]`.
- R9: In single-wire slave mode, MISO is the shared line. It is driven only when `cur_ddr[1]`=1 and SS is low, and its pin level is the serial input. MOSI is general purpose: `mosi_oe`=`cur_ddr[0]` and `mosi_o`=`gpo_dat[0]`.
- R10: In two-wire master mode, MOSI carries the outgoing bits (`mosi_oe`=`cur_ddr[0]`), MISO is the serial input, and SCK is driven when `cur_ddr[2]`=1.
- R11: With `wom`=1, any pin whose output value is 1 is released (`*_oe`=0), and a 0 is still driven.
- R12: A slave loads `tx_data` on `tx_start` while SS is high. While SS is low it drives the byte on MISO (if `cur_ddr[1]`=1), samples MOSI on SCK rising and reports the received byte with a `done` pulse after the 8th falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spe | input | 1 | Engine enable |
| bidi | input | 1 | Single-wire data mode select |
| ssoe | input | 1 | Automatic select output enable |
| wom | input | 1 | Open-drain style output for all pins |
| sppr | input | PW | Prescale field of the clock divisor |
| spr | input | RW | Power-of-two field of the clock divisor |
| cfg_wr | input | 1 | Load strobe for role and direction bits |
| cfg_mstr | input | 1 | Role to load (1 = master) |
| cfg_ddr | input | 4 | Direction bits to load: 0 MOSI, 1 MISO, 2 SCK, 3 SS |
| gpo_dat | input | 2 | General-purpose output levels: 0 MOSI, 1 MISO |
| fault_clr | input | 1 | Clears the sticky fault flag |
| tx_data | input | DW | Byte to transmit |
| tx_start | input | 1 | Start (master) or load (slave) strobe |
| rx_data | output | DW | Last received byte |
| done | output | 1 | One-cycle end-of-byte strobe |
| busy | output | 1 | Transfer running or slave selected |
| cur_mstr | output | 1 | Current role bit |
| cur_ddr | output | 4 | Current direction bits |
| fault | output | 1 | Sticky mode-fault flag |
| mosi_i | input | 1 | MOSI pin level |
| mosi_o | output | 1 | MOSI output value |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin level |
| miso_o | output | 1 | MISO output value |
| miso_oe | output | 1 | MISO output enable |
| sck_i | input | 1 | SCK pin level |
| sck_o | output | 1 | SCK output value |
| sck_oe | output | 1 | SCK output enable |
| ss_i | input | 1 | SS pin level |
| ss_o | output | 1 | SS output value |
| ss_oe | output | 1 | SS output enable |

## Verification
A mode fault can arrive in the same cycle as a transfer request. It can also arrive while bits are already being shifted. The bench provokes the first case by pulling the SS line low on the same edge that `tx_start` is presented, and the second by pulling SS low about a hundred cycles into a slow transfer. In both cases the fault must win: `fault` is set, `cur_mstr` clears and the direction bits follow R7. No `done` may appear during a long window afterwards, and SCK must settle low.

// File: rtl/spi1w_pkg.sv
package spi1w_pkg;
  localparam int PIN_MOSI = 0;
  localparam int PIN_MISO = 1;
  localparam int PIN_SCK  = 2;
  localparam int PIN_SS   = 3;
  localparam int NPINS    = 4;
endpackage

// File: rtl/spi1w_baud.sv
// Half-period tick generator for the master serial clock.
module spi1w_baud #(
  parameter int PW = 3,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] sppr,
  input  logic [RW-1:0] spr,
  output logic          tick
);
  localparam int CW = PW + (1 << RW);

  logic [CW-1:0] half;
  logic [CW-1:0] cnt;

  // half period = (prescale + 1) << rate
  assign half = (CW'(sppr) + CW'(1)) << spr;
  assign tick = run && (cnt == half - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/spi1w_shift.sv
// Byte shift engine: master sequencing from baud ticks, slave from sampled SCK.
module spi1w_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spe,
  input  logic          is_mstr,
  input  logic          start,
  input  logic          abort,
  input  logic          tick,
  input  logic          sin,
  input  logic          sck_in,
  input  logic          ss_sel,
  input  logic [DW-1:0] tx_data,
  output logic          m_run,
  output logic          sck_out,
  output logic          sout,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_data
);
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sh;
  logic [DW-1:0] nxt;
  logic          samp;
  logic [BW-1:0] bcnt;
  logic          s1, s2;
  logic          slv_on, srise, sfall, last;

  assign nxt    = {sh[DW-2:0], samp};
  assign slv_on = spe && !is_mstr && ss_sel;
  assign srise  = s1 && !s2;
  assign sfall  = !s1 && s2;
  assign last   = (bcnt == BW'(DW-1));
  assign sout   = sh[DW-1];
  assign busy   = m_run || slv_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0; samp <= 1'b0; bcnt <= '0; m_run <= 1'b0; sck_out <= 1'b0;
      done <= 1'b0; rx_data <= '0; s1 <= 1'b0; s2 <= 1'b0;
    end else begin
      s1   <= sck_in;
      s2   <= s1;
      done <= 1'b0;
      if (is_mstr) begin
        if (m_run) begin
          if (abort || !spe) begin
            m_run <= 1'b0; sck_out <= 1'b0; bcnt <= '0;
          end else if (tick) begin
            sck_out <= !sck_out;
            if (!sck_out) samp <= sin;
            else begin
              sh <= nxt;
              if (last) begin
                m_run <= 1'b0; done <= 1'b1; rx_data <= nxt; bcnt <= '0;
              end else bcnt <= bcnt + BW'(1);
            end
          end
        end else if (start && spe && !abort) begin
          m_run <= 1'b1; sh <= tx_data; bcnt <= '0; sck_out <= 1'b0;
        end
      end else begin
        m_run   <= 1'b0;
        sck_out <= 1'b0;
        if (!slv_on) begin
          bcnt <= '0;
          if (start) sh <= tx_data;
        end else if (srise) samp <= sin;
        else if (sfall) begin
          sh <= nxt;
          if (last) begin
            done <= 1'b1; rx_data <= nxt; bcnt <= '0;
          end else bcnt <= bcnt + BW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spi1w_pins.sv
// Pin routing: role, data mode, automatic select and open-drain release.
module spi1w_pins import spi1w_pkg::*; (
  input  logic             spe,
  input  logic             is_mstr,
  input  logic             bidi,
  input  logic             auto_ss,
  input  logic             wom,
  input  logic             busy,
  input  logic             sout,
  input  logic             sck_out,
  input  logic             ss_i,
  input  logic             mosi_i,
  input  logic             miso_i,
  input  logic [NPINS-1:0] ddr,
  input  logic [1:0]       gpo,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe,
  output logic             sin
);
  logic [NPINS-1:0] raw_o, raw_oe;

  always_comb begin
    raw_o  = '0;
    raw_oe = '0;
    sin    = 1'b0;
    if (spe) begin
      if (is_mstr) begin
        raw_o[PIN_MOSI]  = sout;
        raw_oe[PIN_MOSI] = ddr[PIN_MOSI];
        raw_o[PIN_SCK]   = sck_out;
        raw_oe[PIN_SCK]  = ddr[PIN_SCK];
        if (bidi) begin
          sin              = mosi_i;
          raw_o[PIN_MISO]  = gpo[1];
          raw_oe[PIN_MISO] = ddr[PIN_MISO];
        end else sin = miso_i;
      end else begin
        raw_o[PIN_MISO]  = sout;
        raw_oe[PIN_MISO] = ddr[PIN_MISO] && !ss_i;
        if (bidi) begin
          sin              = miso_i;
          raw_o[PIN_MOSI]  = gpo[0];
          raw_oe[PIN_MOSI] = ddr[PIN_MOSI];
        end else sin = mosi_i;
      end
      if (auto_ss) begin
        raw_o[PIN_SS]  = !busy;
        raw_oe[PIN_SS] = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    assign pin_o[k]  = raw_o[k];
    assign pin_oe[k] = raw_oe[k] && !(wom && raw_o[k]);
  end
endmodule

// File: rtl/spi1w_core.sv
module spi1w_core import spi1w_pkg::*; #(
  parameter int DW = 8,
  parameter int PW = 3,
  parameter int RW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spe,
  input  logic             bidi,
  input  logic             ssoe,
  input  logic             wom,
  input  logic [PW-1:0]    sppr,
  input  logic [RW-1:0]    spr,
  input  logic             cfg_wr,
  input  logic             cfg_mstr,
  input  logic [NPINS-1:0] cfg_ddr,
  input  logic [1:0]       gpo_dat,
  input  logic             fault_clr,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_start,
  output logic [DW-1:0]    rx_data,
  output logic             done,
  output logic             busy,
  output logic             cur_mstr,
  output logic [NPINS-1:0] cur_ddr,
  output logic             fault,
  input  logic             mosi_i,
  output logic             mosi_o,
  output logic             mosi_oe,
  input  logic             miso_i,
  output logic             miso_o,
  output logic             miso_oe,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  input  logic             ss_i,
  output logic             ss_o,
  output logic             ss_oe
);
  logic             mstr_q, fault_q;
  logic [NPINS-1:0] ddr_q;
  logic             auto_ss, fault_cond;
  logic             tick, m_run, sck_int, sout, sin;
  logic [NPINS-1:0] pin_o, pin_oe;

  assign auto_ss    = spe && mstr_q && ssoe && ddr_q[PIN_SS];
  assign fault_cond = spe && mstr_q && !auto_ss && !ss_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mstr_q <= 1'b0; ddr_q <= '0; fault_q <= 1'b0;
    end else if (fault_cond) begin
      fault_q         <= 1'b1;
      mstr_q          <= 1'b0;
      ddr_q[PIN_MOSI] <= 1'b0;
      ddr_q[PIN_SCK]  <= 1'b0;
      if (!bidi) ddr_q[PIN_MISO] <= 1'b0;
    end else begin
      if (cfg_wr) begin
        mstr_q <= cfg_mstr;
        ddr_q  <= cfg_ddr;
      end
      if (fault_clr) fault_q <= 1'b0;
    end
  end

  spi1w_baud #(.PW(PW), .RW(RW)) u_baud (
    .clk(clk), .rst(rst), .run(m_run), .sppr(sppr), .spr(spr), .tick(tick)
  );

  spi1w_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .spe(spe), .is_mstr(mstr_q), .start(tx_start),
    .abort(fault_cond), .tick(tick), .sin(sin), .sck_in(sck_i), .ss_sel(!ss_i),
    .tx_data(tx_data), .m_run(m_run), .sck_out(sck_int), .sout(sout),
    .busy(busy), .done(done), .rx_data(rx_data)
  );

  spi1w_pins u_pins (
    .spe(spe), .is_mstr(mstr_q), .bidi(bidi), .auto_ss(auto_ss), .wom(wom),
    .busy(busy), .sout(sout), .sck_out(sck_int), .ss_i(ss_i), .mosi_i(mosi_i),
    .miso_i(miso_i), .ddr(ddr_q), .gpo(gpo_dat), .pin_o(pin_o), .pin_oe(pin_oe),
    .sin(sin)
  );

  assign cur_mstr = mstr_q;
  assign cur_ddr  = ddr_q;
  assign fault    = fault_q;
  assign mosi_o   = pin_o[PIN_MOSI];
  assign mosi_oe  = pin_oe[PIN_MOSI];
  assign miso_o   = pin_o[PIN_MISO];
  assign miso_oe  = pin_oe[PIN_MISO];
  assign sck_o    = pin_o[PIN_SCK];
  assign sck_oe   = pin_oe[PIN_SCK];
  assign ss_o     = pin_o[PIN_SS];
  assign ss_oe    = pin_oe[PIN_SS];
endmodule

// File: rtl/spi1w_chk.sv
module spi1w_chk (
  input logic       clk,
  input logic       rst,
  input logic       spe,
  input logic       ssoe,
  input logic       wom,
  input logic       done,
  input logic       busy,
  input logic       cur_mstr,
  input logic [3:0] cur_ddr,
  input logic       fault,
  input logic       fault_clr,
  input logic       ss_i,
  input logic       ss_o,
  input logic       ss_oe,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       mosi_o,
  input logic       mosi_oe,
  input logic       miso_o,
  input logic       miso_oe
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (cur_mstr && !busy && sck_oe) |-> !sck_o); // R2
  AST_SS_LOW_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    (spe && cur_mstr && ssoe && cur_ddr[3] && busy) |-> (ss_oe && !ss_o)); // R3
  AST_SS_INPUT_SLAVE: assert property (@(posedge clk) disable iff (rst)
    !cur_mstr |-> !ss_oe); // R4
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fault && !fault_clr) |=> fault); // R5
  AST_FAULT_DEMOTES: assert property (@(posedge clk) disable iff (rst)
    (spe && cur_mstr && !ss_i && !(ssoe && cur_ddr[3])) |=> (fault && !cur_mstr)); // R5
  AST_NO_FAULT_AUTO_SS: assert property (@(posedge clk) disable iff (rst)
    (cur_mstr && ssoe && cur_ddr[3] && !fault) |=> !fault); // R6
  AST_OPEN_DRAIN: assert property (@(posedge clk) disable iff (rst)
    wom |-> !((mosi_oe && mosi_o) || (miso_oe && miso_o) ||
              (sck_oe && sck_o) || (ss_oe && ss_o))); // R11
endmodule

bind spi1w_core spi1w_chk u_chk (.*);

// File: tb/test_spi1w_core.sv
`timescale 1ns/1ps
module test_spi1w_core;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, spe, bidi, ssoe, wom, cfg_wr, cfg_mstr, fault_clr, tx_start;
  logic [2:0] sppr, spr;
  logic [3:0] cfg_ddr, cur_ddr;
  logic [1:0] gpo_dat;
  logic [7:0] tx_data, rx_data;
  logic       done, busy, cur_mstr, fault;
  logic       mosi_i, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;
  logic       sck_i, sck_o, sck_oe, ss_i, ss_o, ss_oe;

  // bench-side pin environment
  logic       tb_mode, tb_dat, tb_sck, tb_ss, tb_ss_force;
  logic [7:0] bslv, brx;
  int         nfall = 0, base = 0;
  logic       ext_dat, mosi_pin, miso_pin, sck_pin;
  int         tests = 0, fails = 0, dcnt = 0;

  always_comb begin
    int idx;
    idx = nfall - base;
    if (tb_mode) ext_dat = tb_dat;
    else if (idx >= 0 && idx < 8) ext_dat = bslv[3'(7 - idx)];
    else ext_dat = 1'b0;
  end
  assign mosi_pin = mosi_oe ? mosi_o : ext_dat;
  assign miso_pin = miso_oe ? miso_o : ext_dat;
  assign sck_pin  = sck_oe ? sck_o : tb_sck;
  assign mosi_i   = mosi_pin;
  assign miso_i   = miso_pin;
  assign sck_i    = sck_pin;
  assign ss_i     = tb_ss_force ? 1'b0 : (ss_oe ? ss_o : tb_ss);

  always @(negedge sck_pin) nfall = nfall + 1;
  always @(posedge sck_pin) brx <= {brx[6:0], mosi_pin};
  always @(negedge clk) if (done) dcnt = dcnt + 1;

  spi1w_core i_spi1w_core (.*);

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // {bidi, ddr0, sppr[2:0], spr[2:0], tx[7:0], slave byte[7:0], expected rx[7:0]}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'h40_A5_3C_3C, 32'h51_81_7E_7E, 32'hC8_5A_00_5A,
    32'h81_FF_C3_C3, 32'h7A_00_FF_FF, 32'h4B_3C_A5_A5 };

  task automatic cfg(input logic m, input logic [3:0] d);
    @(negedge clk); cfg_mstr = m; cfg_ddr = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic run_vec(input logic [31:0] v);
    logic bd, d0, prev, ss_bad, mosi_drv, miso_bad;
    logic [7:0] tx, sl, ex, got;
    int half, r1, r2, nd;
    bd = v[31]; d0 = v[30]; tx = v[23:16]; sl = v[15:8]; ex = v[7:0];
    half = (int'(v[29:27]) + 1) << v[26:24];
    bidi = bd; sppr = v[29:27]; spr = v[26:24]; ssoe = 1'b1; gpo_dat = 2'b10;
    tb_mode = 1'b0; bslv = sl; base = nfall;
    cfg(1'b1, {3'b111, d0});
    tx_data = tx; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    r1 = -1; r2 = -1; nd = 0; prev = 1'b0; got = 8'h00;
    ss_bad = 1'b0; mosi_drv = 1'b0; miso_bad = 1'b0;
    for (int c = 0; c < 2000; c++) begin
      if (sck_oe && sck_o && !prev) begin
        if (r1 < 0) r1 = c; else if (r2 < 0) r2 = c;
      end
      prev = sck_o;
      if (busy && !(ss_oe && !ss_o)) ss_bad = 1'b1;
      if (bd && !d0 && mosi_oe) mosi_drv = 1'b1;
      if (bd && !(miso_oe && miso_o)) miso_bad = 1'b1;
      if (done) begin nd++; got = rx_data; end
      if (!busy) break;
      @(negedge clk);
    end
    chk("R2 received byte", 32'(got), 32'(ex));
    chk("R2 one done pulse", 32'(nd), 32'd1);
    chk("R1 sck period", 32'(r2 - r1), 32'(2 * half));
    chk("R3 ss low while busy", 32'(ss_bad), 32'd0);
    chk("R3 ss high when idle", 32'({ss_oe, ss_o}), 32'h3);
    chk("R10 MSB-first bits on MOSI", 32'(brx), 32'((bd && !d0) ? sl : tx));
    if (bd) begin
      chk("R8 shared MOSI not driven as input", 32'(mosi_drv), 32'd0);
      chk("R8 MISO general purpose", 32'(miso_bad), 32'd0);
    end else chk("R10 MISO input in master", 32'(miso_oe), 32'd0);
  endtask

  task automatic slave_xfer(input logic [7:0] din, output logic [7:0] dout);
    dout = 8'h00;
    for (int b = 7; b >= 0; b--) begin
      tb_dat = din[b];
      repeat (4) @(negedge clk);
      dout = {dout[6:0], miso_pin};
      tb_sck = 1'b1;
      repeat (4) @(negedge clk);
      tb_sck = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #750000;
    fails++; tests++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int d0c;
    rst = 1'b1; spe = 1'b0; bidi = 1'b0; ssoe = 1'b0; wom = 1'b0; cfg_wr = 1'b0;
    cfg_mstr = 1'b0; cfg_ddr = 4'h0; gpo_dat = 2'b00; fault_clr = 1'b0;
    tx_start = 1'b0; tx_data = 8'h00; sppr = 3'd0; spr = 3'd0;
    tb_mode = 1'b0; tb_dat = 1'b0; tb_sck = 1'b0; tb_ss = 1'b1; tb_ss_force = 1'b0;
    bslv = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R2 reset busy/done", 32'({busy, done}), 32'd0);
    chk("R5 reset fault/role", 32'({fault, cur_mstr}), 32'd0);
    chk("R4 no pin driven when disabled", 32'({mosi_oe, miso_oe, sck_oe, ss_oe}), 32'd0);

    spe = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R5: fault in the same cycle as a start request
    bidi = 1'b0; ssoe = 1'b0; tb_ss = 1'b1;
    cfg(1'b1, 4'b0111);
    d0c = dcnt;
    tb_ss = 1'b0; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    chk("R5 fault set", 32'(fault), 32'd1);
    chk("R5 master bit cleared", 32'(cur_mstr), 32'd0);
    chk("R7 normal-mode fault clears MOSI/MISO/SCK", 32'(cur_ddr), 32'h0);
    tb_ss = 1'b1;
    repeat (40) @(negedge clk);
    chk("R5 start ignored, no done", 32'(dcnt - d0c), 32'd0);
    chk("R5 fault sticky", 32'(fault), 32'd1);
    fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;
    chk("R5 fault cleared", 32'(fault), 32'd0);

    // R5/R7: fault in the middle of a slow single-wire transfer
    bidi = 1'b1; sppr = 3'd7; spr = 3'd2;
    cfg(1'b1, 4'b0111);
    tx_data = 8'h33; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    repeat (100) @(negedge clk);
    chk("R2 transfer running", 32'(busy), 32'd1);
    d0c = dcnt;
    tb_ss = 1'b0;
    @(negedge clk);
    tb_ss = 1'b1;
    chk("R7 bidi fault keeps MISO bit", 32'(cur_ddr), 32'b0010);
    @(negedge clk);
    chk("R5 aborted, sck not driven high", 32'(sck_oe && sck_o), 32'd0);
    repeat (600) @(negedge clk);
    chk("R5 aborted transfer gives no done", 32'(dcnt - d0c), 32'd0);
    fault_clr = 1'b1;
    @(negedge clk); fault_clr = 1'b0;

    // R6: automatic select suppresses mode fault
    bidi = 1'b0; ssoe = 1'b1;
    cfg(1'b1, 4'b1111);
    tb_ss_force = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 no fault with automatic SS", 32'(fault), 32'd0);
    chk("R6 still master", 32'(cur_mstr), 32'd1);
    tb_ss_force = 1'b0;

    // R11: open-drain release
    wom = 1'b1;
    @(negedge clk);
    chk("R11 high SS released", 32'(ss_oe), 32'd0);
    chk("R11 low SCK still driven", 32'({sck_oe, sck_o}), 32'b10);
    wom = 1'b0;
    @(negedge clk);
    chk("R3 SS driven high when idle", 32'({ss_oe, ss_o}), 32'b11);

    // R12: two-wire slave transfer
    ssoe = 1'b0; tb_mode = 1'b1; tb_sck = 1'b0; tb_ss = 1'b1;
    cfg(1'b0, 4'b0010);
    tx_data = 8'h96; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    tb_ss = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 slave drives MISO when selected", 32'(miso_oe), 32'd1);
    chk("R4 slave leaves SCK and SS undriven", 32'({sck_oe, ss_oe}), 32'd0);
    d0c = dcnt;
    slave_xfer(8'h4B, got);
    chk("R12 slave received byte", 32'(rx_data), 32'h4B);
    chk("R12 slave sent byte MSB first", 32'(got), 32'h96);
    chk("R12 slave done once", 32'(dcnt - d0c), 32'd1);
    tb_ss = 1'b1;

    // R9: single-wire slave, shared MISO as input, MOSI general purpose
    bidi = 1'b1; gpo_dat = 2'b01;
    cfg(1'b0, 4'b0001);
    tb_ss = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 MOSI general-purpose output", 32'({mosi_oe, mosi_o}), 32'b11);
    chk("R9 shared MISO input not driven", 32'(miso_oe), 32'd0);
    slave_xfer(8'hE1, got);
    chk("R9 shifted in from shared MISO", 32'(rx_data), 32'hE1);
    tb_ss = 1'b1;
    cfg(1'b0, 4'b0011);
    tb_ss = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 shared MISO driven as output", 32'(miso_oe), 32'd1);
    tb_ss = 1'b1;
    @(negedge clk);
    chk("R9 shared MISO released when deselected", 32'(miso_oe), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule